// File: doc/BRIEF.md
# Half-Bridge Switch Controller with Current Limiting

This block drives one half-bridge from a single PWM level. Each system clock it chooses between three switch states: high switch on, low switch on, or both off. The choice depends on the PWM input, the current-trip flags, a bootstrap-supply warning, a per-bridge enable reset and a force-off request from a supervisor. The PWM input is asynchronous and passes through a synchronizer. Every hand-over between the two switches goes through a programmable interval with both switches off.

A three-bit mode code selects how current trips are handled:

- **Limiting mode.** Trips hold a per-cycle override that lasts until the next synchronized PWM rising edge. A high-switch trip moves the bridge onto its low switch. A low-switch trip leaves both switches off. A severe trip latches a shutdown.
- **Latching mode.** Any trip at all latches a high-impedance shutdown. Only a rising edge of the bridge reset clears it, and only once every trip flag has dropped.

Top module: `hb_ctrl`

## Requirements
- R1: Outside shutdown and override, a synchronized PWM high gives `hs_on`=1 and `ls_on`=0. A synchronized PWM low gives `hs_on`=0 and `ls_on`=1. `hiz` is 0 in both cases.
- R2: `hs_on` and `ls_on` are never 1 together. At every hand-over between them, both are 0 for exactly DEAD_CYC clock cycles (default 4).
- R3: `mode_sel`=3'b001 selects limiting mode and 3'b011 selects latching mode. Every other code behaves as latching mode.
- R4: In limiting mode, `oc_hi`=1 turns the high switch off and, after the dead interval, the low switch on. This holds until the next PWM rising edge, and `oc_latched` stays 0.
- R5: In limiting mode, `oc_lo`=1 leaves both switches off with `hiz`=0 until the next PWM rising edge, and `oc_latched` stays 0.
- R6: In limiting mode, `oc_severe`=1 sets `oc_latched` and `hiz` and turns both switches off. PWM edges do not release this state.
- R7: In latching mode, any of `oc_hi`, `oc_lo` or `oc_severe` sets `oc_latched` and `hiz` and clears both switch outputs on the first clock edge that samples it.
- R8: `oc_latched` clears only on a rising edge of `br_rst_n` that occurs while all three trip flags are 0. Neither the removal of the trip nor a reset edge taken during a trip clears it.
- R9: While `br_rst_n`=0, both switches are off, `hiz`=1 and `pulldown_en`=1.
- R10: A `bst_uv` pulse turns the high switch off and holds the low switch on for at least RECHARGE_CYC cycles (default 8) and at most RECHARGE_CYC+1 cycles, after which PWM control resumes.
- R11: `force_off`=1 gives `hiz`=1 with both switches off and does not touch `oc_latched`. When it drops, normal switching resumes.
- R12: While `rst_n`=0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pwm_in | input | 1 | Asynchronous PWM level |
| mode_sel | input | 3 | Trip handling mode code |
| oc_hi | input | 1 | High-switch over-current flag |
| oc_lo | input | 1 | Low-switch over-current flag |
| oc_severe | input | 1 | Uncontrollable over-current flag |
| bst_uv | input | 1 | Bootstrap supply under-voltage flag |
| br_rst_n | input | 1 | Active-low bridge reset, synchronous |
| force_off | input | 1 | Supervisor shutdown request |
| hs_on | output | 1 | High switch on |
| ls_on | output | 1 | Low switch on |
| hiz | output | 1 | Bridge held in high impedance |
| pulldown_en | output | 1 | Weak output pulldown enable |
| oc_latched | output | 1 | Latched over-current shutdown |

## Verification
The internal state consists of a per-cycle override, a shutdown latch, a recharge timer and the dead-time counter. A wrong value in any of them appears at the switch outputs within one dead interval plus two clocks, and a wrong latch appears at once on `oc_latched` and `hiz`.

The directed scenarios are arranged so that each state difference shows up as a difference in switch levels. A stuck override keeps the low switch on across a PWM edge. A lost latch lets switching resume without a reset edge. A miscounted dead interval changes the measured number of both-off cycles at a hand-over.

// File: rtl/hb_ctrl_pkg.sv
package hb_ctrl_pkg;
   typedef enum logic [1:0] {
      SW_OFF  = 2'd0,
      SW_HIGH = 2'd1,
      SW_LOW  = 2'd2
   } sw_state_t;

   typedef enum logic [1:0] {
      OVR_NONE      = 2'd0,
      OVR_FORCE_LOW = 2'd1,
      OVR_ALL_OFF   = 2'd2
   } ovr_t;

   localparam logic [2:0] MODE_LIMIT = 3'b001;
   localparam logic [2:0] MODE_LATCH = 3'b011;
endpackage

// File: rtl/hb_pwm_sync.sv
module hb_pwm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   output logic pwm_lvl,
   output logic pwm_rise
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign pwm_lvl = pwm_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else if (STAGES == 1) sh_q <= pwm_in;
            else sh_q <= {sh_q[STAGES-2+((STAGES==1)?1:0):0], pwm_in};
         end
         assign pwm_lvl = sh_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pwm_lvl;
   end

   assign pwm_rise = pwm_lvl & ~prev_q;

   a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_rise |=> !pwm_rise);
endmodule

// File: rtl/hb_prot.sv
module hb_prot
   import hb_ctrl_pkg::*;
#(
   parameter int RECHARGE_CYC = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic [2:0] mode_sel,
   input  logic      pwm_lvl,
   input  logic      pwm_rise,
   input  logic      oc_hi,
   input  logic      oc_lo,
   input  logic      oc_severe,
   input  logic      bst_uv,
   input  logic      br_rst_n,
   input  logic      force_off,
   input  logic      ls_active,
   output sw_state_t req,
   output logic      shut,
   output ovr_t      ovr,
   output logic      oc_latched,
   output logic      hiz,
   output logic      pulldown_en
);
   localparam int CW = $clog2(RECHARGE_CYC + 1);
   localparam logic [CW-1:0] RLOAD = CW'(RECHARGE_CYC);

   generate
      if (RECHARGE_CYC < 1) begin : g_bad_rech
         $error("RECHARGE_CYC must be at least 1");
      end
   endgenerate

   logic          limit_mode, any_oc, latch_set, br_rise, br_prev_q;
   logic          latch_q;
   ovr_t          ovr_q;
   logic [CW-1:0] rech_q;

   assign limit_mode = (mode_sel == MODE_LIMIT);
   assign any_oc     = oc_hi | oc_lo | oc_severe;
   assign latch_set  = oc_severe | (~limit_mode & (oc_hi | oc_lo));
   assign br_rise    = br_rst_n & ~br_prev_q;
   assign shut       = ~br_rst_n | force_off | latch_q | latch_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_prev_q   <= 1'b0;
         latch_q     <= 1'b0;
         ovr_q       <= OVR_NONE;
         rech_q      <= '0;
         hiz         <= 1'b0;
         pulldown_en <= 1'b0;
      end else begin
         br_prev_q   <= br_rst_n;
         hiz         <= shut;
         pulldown_en <= ~br_rst_n;

         if (latch_set)             latch_q <= 1'b1;
         else if (br_rise && !any_oc) latch_q <= 1'b0;

         if (shut || !limit_mode)   ovr_q <= OVR_NONE;
         else if (oc_lo)            ovr_q <= OVR_ALL_OFF;
         else if (oc_hi)            ovr_q <= OVR_FORCE_LOW;
         else if (pwm_rise)         ovr_q <= OVR_NONE;

         if (shut)                          rech_q <= '0;
         else if (rech_q == '0 && bst_uv)   rech_q <= RLOAD;
         else if (rech_q != '0 && ls_active) rech_q <= rech_q - 1'b1;
      end
   end

   always_comb begin
      if (shut)                     req = SW_OFF;
      else if (ovr_q == OVR_ALL_OFF)   req = SW_OFF;
      else if (ovr_q == OVR_FORCE_LOW) req = SW_LOW;
      else if (rech_q != '0)        req = SW_LOW;
      else if (pwm_lvl)             req = SW_HIGH;
      else                          req = SW_LOW;
   end

   assign ovr        = ovr_q;
   assign oc_latched = latch_q;

   a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_latched && !(br_rst_n && !br_prev_q)) |=> oc_latched);
   a_r8_clear_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_latched && any_oc) |=> oc_latched);
   a_r6_severe_latches: assert property (@(posedge clk) disable iff (!rst_n)
      oc_severe |=> (oc_latched && hiz));
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
   import hb_ctrl_pkg::*;
#(
   parameter int DEAD_CYC = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  sw_state_t req,
   output logic      hs_on,
   output logic      ls_on
);
   localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("DEAD_CYC must be at least 1");
      end
   endgenerate

   sw_state_t     cur_q;
   logic [CW-1:0] off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= SW_OFF;
         off_q <= '0;
      end else if (cur_q != SW_OFF) begin
         if (req != cur_q) begin
            cur_q <= SW_OFF;
            off_q <= '0;
         end
      end else begin
         if (req != SW_OFF && off_q == LAST) cur_q <= req;
         else if (off_q != LAST)             off_q <= off_q + 1'b1;
      end
   end

   assign hs_on = (cur_q == SW_HIGH);
   assign ls_on = (cur_q == SW_LOW);

   a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_on && ls_on));
   a_r2_gap_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ls_on) |=> !hs_on);
   a_r2_gap_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_on) |=> !ls_on);
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
   import hb_ctrl_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DEAD_CYC     = 4,
   parameter int RECHARGE_CYC = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_in,
   input  logic [2:0] mode_sel,
   input  logic       oc_hi,
   input  logic       oc_lo,
   input  logic       oc_severe,
   input  logic       bst_uv,
   input  logic       br_rst_n,
   input  logic       force_off,
   output logic       hs_on,
   output logic       ls_on,
   output logic       hiz,
   output logic       pulldown_en,
   output logic       oc_latched
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic      pwm_lvl, pwm_rise, shut_w;
   sw_state_t req_w;
   ovr_t      ovr_w;

   hb_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
      .pwm_lvl(pwm_lvl), .pwm_rise(pwm_rise)
   );

   hb_prot #(.RECHARGE_CYC(RECHARGE_CYC)) u_prot (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .pwm_lvl(pwm_lvl), .pwm_rise(pwm_rise),
      .oc_hi(oc_hi), .oc_lo(oc_lo), .oc_severe(oc_severe),
      .bst_uv(bst_uv), .br_rst_n(br_rst_n), .force_off(force_off),
      .ls_active(ls_on), .req(req_w), .shut(shut_w), .ovr(ovr_w),
      .oc_latched(oc_latched), .hiz(hiz), .pulldown_en(pulldown_en)
   );

   hb_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
      .clk(clk), .rst_n(rst_n), .req(req_w),
      .hs_on(hs_on), .ls_on(ls_on)
   );

   a_r7_shut_kills_switches: assert property (@(posedge clk) disable iff (!rst_n)
      shut_w |=> (!hs_on && !ls_on));
   a_r4_force_low_no_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_w == OVR_FORCE_LOW && !shut_w) |=> !hs_on);
   a_r5_all_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_w == OVR_ALL_OFF && !shut_w) |=> (!hs_on && !ls_on));
   a_r9_pulldown: assert property (@(posedge clk) disable iff (!rst_n)
      !br_rst_n |=> (pulldown_en && hiz));
endmodule

// File: tb/sim_hb_ctrl.sv
`timescale 1ns/1ps
module sim_hb_ctrl;
   localparam int DEAD = 4;
   localparam int RECH = 8;

   logic clk = 1'b0;
   logic rst_n, pwm_in, oc_hi, oc_lo, oc_severe, bst_uv, br_rst_n, force_off;
   logic [2:0] mode_sel;
   logic hs_on, ls_on, hiz, pulldown_en, oc_latched;
   int   n_chk = 0, n_err = 0, n_overlap = 0;
   bit   finished = 1'b0;

   always #2.5 clk = ~clk;

   hb_ctrl #(.SYNC_STAGES(2), .DEAD_CYC(DEAD), .RECHARGE_CYC(RECH)) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .mode_sel(mode_sel),
      .oc_hi(oc_hi), .oc_lo(oc_lo), .oc_severe(oc_severe), .bst_uv(bst_uv),
      .br_rst_n(br_rst_n), .force_off(force_off),
      .hs_on(hs_on), .ls_on(ls_on), .hiz(hiz),
      .pulldown_en(pulldown_en), .oc_latched(oc_latched)
   );

   always @(negedge clk) if (rst_n && hs_on && ls_on) n_overlap++;

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(logic [2:0] m, logic p);
      @(negedge clk);
      mode_sel = m; pwm_in = p; oc_hi = 0; oc_lo = 0; oc_severe = 0;
      bst_uv = 0; force_off = 0; br_rst_n = 0;
      cyc(3);
      br_rst_n = 1;
      cyc(15);
   endtask

   task automatic t_reset();
      rst_n = 0; pwm_in = 0; mode_sel = 3'b001; oc_hi = 0; oc_lo = 0;
      oc_severe = 0; bst_uv = 0; br_rst_n = 0; force_off = 0;
      cyc(3);
      check("R12 hs in reset", hs_on, 0);
      check("R12 ls in reset", ls_on, 0);
      check("R12 latch in reset", oc_latched, 0);
      check("R12 hiz in reset", hiz, 0);
      check("R12 pulldown in reset", pulldown_en, 0);
      rst_n = 1;
      cyc(4);
      check("R9 hiz while bridge reset", hiz, 1);
      check("R9 pulldown while bridge reset", pulldown_en, 1);
      check("R9 switches off", hs_on | ls_on, 0);
   endtask

   task automatic t_follow();
      int off;
      restart(3'b001, 1'b1);
      check("R1 high phase hs", hs_on, 1);
      check("R1 high phase ls", ls_on, 0);
      check("R1 hiz low", hiz, 0);
      check("R9 pulldown released", pulldown_en, 0);
      pwm_in = 0;
      off = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ls_on) break;
         if (!hs_on) off++;
      end
      check("R2 dead high-to-low", off, DEAD);
      check("R1 low phase ls", ls_on, 1);
      pwm_in = 1;
      off = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (hs_on) break;
         if (!ls_on) off++;
      end
      check("R2 dead low-to-high", off, DEAD);
   endtask

   task automatic t_cbc_high();
      restart(3'b001, 1'b1);
      oc_hi = 1; cyc(1); oc_hi = 0;
      cyc(12);
      check("R4 high off after trip", hs_on, 0);
      check("R4 low forced on", ls_on, 1);
      check("R4 no latch", oc_latched, 0);
      check("R4 no hiz", hiz, 0);
      pwm_in = 0; cyc(6); pwm_in = 1; cyc(15);
      check("R4 released on new cycle", hs_on, 1);
   endtask

   task automatic t_cbc_low();
      restart(3'b001, 1'b0);
      check("R1 low start", ls_on, 1);
      oc_lo = 1; cyc(1); oc_lo = 0;
      cyc(20);
      check("R5 ls off", ls_on, 0);
      check("R5 hs off", hs_on, 0);
      check("R5 hiz low", hiz, 0);
      check("R5 no latch", oc_latched, 0);
      pwm_in = 1; cyc(15);
      check("R5 released on new cycle", hs_on, 1);
   endtask

   task automatic t_severe();
      restart(3'b001, 1'b1);
      oc_severe = 1; cyc(1); oc_severe = 0;
      cyc(3);
      check("R6 latched", oc_latched, 1);
      check("R6 hiz", hiz, 1);
      pwm_in = 0; cyc(8); pwm_in = 1; cyc(15);
      check("R6 pwm edge does not release", hs_on | ls_on, 0);
      check("R6 still latched", oc_latched, 1);
      br_rst_n = 0; cyc(3); br_rst_n = 1; cyc(15);
      check("R8 cleared by reset edge", oc_latched, 0);
      check("R8 operation resumes", hs_on, 1);
   endtask

   task automatic t_latch_mode();
      restart(3'b011, 1'b1);
      check("R3 latch mode runs", hs_on, 1);
      oc_hi = 1;
      cyc(1);
      check("R7 latched next clock", oc_latched, 1);
      check("R7 hiz next clock", hiz, 1);
      check("R7 hs off next clock", hs_on, 0);
      br_rst_n = 0; cyc(3); br_rst_n = 1; cyc(4);
      check("R8 reset during trip keeps latch", oc_latched, 1);
      oc_hi = 0; cyc(10);
      check("R8 no self recovery", oc_latched, 1);
      br_rst_n = 0; cyc(3); br_rst_n = 1; cyc(15);
      check("R8 reset after trip clears", oc_latched, 0);
      check("R8 resumes high", hs_on, 1);
      pwm_in = 0; cyc(12);
      oc_lo = 1; cyc(1); oc_lo = 0;
      check("R7 low trip latches", oc_latched, 1);
      check("R7 low trip ls off", ls_on, 0);
   endtask

   task automatic t_odd_mode();
      restart(3'b000, 1'b0);
      oc_lo = 1; cyc(1); oc_lo = 0; cyc(2);
      check("R3 unknown code latches", oc_latched, 1);
      check("R3 unknown code hiz", hiz, 1);
   endtask

   task automatic t_bootstrap();
      int lsn;
      restart(3'b001, 1'b1);
      bst_uv = 1; cyc(1); bst_uv = 0;
      lsn = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ls_on) lsn++;
      end
      check("R10 low held long enough", int'(lsn >= RECH && lsn <= RECH + 1), 1);
      check("R10 high resumes", hs_on, 1);
   endtask

   task automatic t_force();
      restart(3'b001, 1'b1);
      force_off = 1; cyc(2);
      check("R11 hiz", hiz, 1);
      check("R11 switches off", hs_on | ls_on, 0);
      check("R11 latch untouched", oc_latched, 0);
      force_off = 0; cyc(12);
      check("R11 resumes", hs_on, 1);
      check("R11 hiz released", hiz, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_follow();
      t_cbc_high();
      t_cbc_low();
      t_severe();
      t_latch_mode();
      t_odd_mode();
      t_bootstrap();
      t_force();
      check("R2 no overlap seen", n_overlap, 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule